// File: doc/BRIEF.md
# Table-Driven Memory Read-Back Checker

This block confirms that a memory region holds a fixed set of expected words. The list of (word address, expected word) pairs is a parameter, so the list is fixed when the design is built. After a start pulse, the block walks the list from entry 0 in list order. For each entry it issues one read command on a native read port: a command channel with valid/ready and a word address, and a response channel with valid/ready and data. Each returned word is compared with the entry it belongs to. Mismatches are counted. When every entry has been read and answered, `done` goes high.

The list may be in any order and may name the same address more than once. The intended use is after a write pass that stores the same list in the same order. In that case memory keeps only the last value written to a repeated address. Each earlier entry for that address then counts as one mismatch. This is an expected outcome, not a fault in the block.

Several reads may be in flight at once, up to a parameter limit. Responses arrive in command order. Each response is matched against the oldest entry still waiting for its data.

Top module: `pattern_checker`

## Requirements
- R1: While reset is low, and after it is released, `done` is 0, `err_count` is 0 and `cmd_valid` is 0.
- R2: A start pulse while no pass is running begins a pass from entry 0 and clears the count and `done`. A start pulse during a pass has no effect on the pass or on the final count.
- R3: Read commands follow table order exactly, one command per entry. `cmd_addr` carries the entry's word address unchanged, so entry address 7 on a 32-bit port means byte offset 0x1C.
- R4: A new command may be issued before earlier responses return. The number of commands awaiting a response never exceeds OUTS, and `cmd_valid` is high exactly when a pass runs, entries remain and fewer than OUTS reads are outstanding.
- R5: Each accepted response is compared with the data of the oldest outstanding entry. A mismatch raises `err_count` by exactly one, and a match leaves it unchanged.
- R6: `done` rises one cycle after the cycle in which a running pass has issued all entries and has no read outstanding. It stays high until the next accepted start, and `cmd_valid` is low while `done` is high.
- R7: After the table has been written in order, a pass reports exactly one error for each entry whose address is written again later in the table.
- R8: A command held off by `cmd_ready` low keeps `cmd_valid` high and `cmd_addr` stable.
- R9: `rsp_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a pass |
| cmd_valid | output | 1 | Read command valid |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_addr | output | AW | Word address of the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Checker accepts read data |
| rsp_data | input | DW | Read data word |
| done | output | 1 | Pass finished |
| err_count | output | clog2(DEPTH+1) | Mismatches seen in the current or last pass |

## Verification
The two functions that collide are issuing a new command and retiring the oldest outstanding read. Both happen in the same cycle whenever the memory answers with one cycle of latency while commands keep flowing. Then the in-flight queue pushes and pops at the same edge.

The bench provokes this with an always-ready memory. It also provokes the case where the limit is full and a response frees a slot in the same cycle as the next command. It does this with a stalled response channel and a small OUTS.

A behavioural model built from queues judges every cycle. It checks `cmd_valid`, the issued address, `err_count` and `done` against what the requirements predict.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  // Wrapping increment used by the in-flight queue pointers.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/pchk_table.sv
module pchk_table #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter logic [DEPTH*AW-1:0] ADDRS = '0,
  parameter logic [DEPTH*DW-1:0] DATAS = '0,
  localparam int unsigned IW = $clog2(DEPTH + 1),
  localparam int unsigned SW = $clog2(DEPTH)
) (
  input  logic [IW-1:0] a_idx,
  input  logic [IW-1:0] d_idx,
  output logic [AW-1:0] a_out,
  output logic [DW-1:0] d_out
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH);
  logic [AW-1:0] addr_arr [DEPTH];
  logic [DW-1:0] data_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign addr_arr[g] = ADDRS[g*AW +: AW];
    assign data_arr[g] = DATAS[g*DW +: DW];
  end

  assign a_out = (a_idx < LAST) ? addr_arr[a_idx[SW-1:0]] : '0;
  assign d_out = (d_idx < LAST) ? data_arr[d_idx[SW-1:0]] : '0;
endmodule

// File: rtl/pchk_issue.sv
module pchk_issue
  import pchk_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned OUTS  = 4,
  localparam int unsigned IW = $clog2(DEPTH + 1),
  localparam int unsigned PW = $clog2(OUTS),
  localparam int unsigned CW = $clog2(OUTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmd_ready,
  input  logic          rsp_valid,
  output logic          cmd_valid,
  output logic [IW-1:0] issue_idx,
  output logic [IW-1:0] cmp_idx,
  output logic          pass_begin,
  output logic          cmd_fire,
  output logic          rsp_fire,
  output logic          done
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH);
  localparam logic [CW-1:0] CMAX = CW'(OUTS);

  logic          running_q;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [IW-1:0] slots [OUTS];
  logic          all_issued, finish;

  assign all_issued = (issue_idx == LAST);
  assign cmd_valid  = running_q && !all_issued && (cnt < CMAX);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign rsp_fire   = rsp_valid && (cnt != '0);
  assign finish     = running_q && all_issued && (cnt == '0);
  assign pass_begin = start && !running_q;
  assign cmp_idx    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done      <= 1'b0;
      issue_idx <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
    end else if (pass_begin) begin
      running_q <= 1'b1;
      done      <= 1'b0;
      issue_idx <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
    end else begin
      if (finish) begin
        running_q <= 1'b0;
        done      <= 1'b1;
      end
      if (cmd_fire) begin
        wr_ptr    <= PW'(wrap_inc(int'(wr_ptr), OUTS));
        issue_idx <= issue_idx + IW'(1);
      end
      if (rsp_fire) rd_ptr <= PW'(wrap_inc(int'(rd_ptr), OUTS));
      cnt <= cnt + CW'(cmd_fire) - CW'(rsp_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_fire) slots[wr_ptr] <= issue_idx;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);
  p_rsp_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cnt != '0));
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && start && !cmd_fire) |=> $stable(issue_idx));
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !pass_begin) |=> (issue_idx == $past(issue_idx) + IW'(1)));
endmodule

// File: rtl/pchk_compare.sv
module pchk_compare #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned EW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rsp_fire,
  input  logic [DW-1:0] rsp_data,
  input  logic [DW-1:0] exp_data,
  output logic [EW-1:0] err_count
);
  logic mismatch;
  assign mismatch = rsp_fire && (rsp_data != exp_data);

  always_ff @(posedge clk) begin
    if (!rst_n)        err_count <= '0;
    else if (clear)    err_count <= '0;
    else if (mismatch) err_count <= err_count + EW'(1);
  end

  p_err_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !rsp_fire) |=> $stable(err_count));
  p_err_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (err_count == '0));
endmodule

// File: rtl/pattern_checker.sv
module pattern_checker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned OUTS  = 4,
  parameter logic [DEPTH*AW-1:0] ADDRS = {8'h01, 8'h02, 8'h07, 8'h00},
  parameter logic [DEPTH*DW-1:0] DATAS = {32'h5EED_0004, 32'h5EED_0003,
                                          32'h5EED_0002, 32'h5EED_0001},
  localparam int unsigned IW = $clog2(DEPTH + 1),
  localparam int unsigned EW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output logic [EW-1:0] err_count
);
  logic [IW-1:0] issue_idx, cmp_idx;
  logic          pass_begin, cmd_fire, rsp_fire;
  logic [DW-1:0] exp_data;

  assign rsp_ready = 1'b1;

  pchk_table #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .ADDRS(ADDRS), .DATAS(DATAS)) u_table (
    .a_idx(issue_idx), .d_idx(cmp_idx), .a_out(cmd_addr), .d_out(exp_data)
  );

  pchk_issue #(.DEPTH(DEPTH), .OUTS(OUTS)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .cmd_valid(cmd_valid), .issue_idx(issue_idx),
    .cmp_idx(cmp_idx), .pass_begin(pass_begin), .cmd_fire(cmd_fire),
    .rsp_fire(rsp_fire), .done(done)
  );

  pchk_compare #(.DEPTH(DEPTH), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(pass_begin), .rsp_fire(rsp_fire),
    .rsp_data(rsp_data), .exp_data(exp_data), .err_count(err_count)
  );

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !start) |=> (cmd_valid && $stable(cmd_addr)));
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!done && err_count == '0 && !cmd_valid));
endmodule

// File: tb/pattern_checker_test.sv
module pattern_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int OUTS = 2;
  localparam int EW = $clog2(DEPTH + 1);
  localparam logic [DEPTH*AW-1:0] T_A = {8'h07, 8'h00, 8'h01, 8'h02, 8'h07, 8'h00};
  localparam logic [DEPTH*DW-1:0] T_D = {32'hDEAD_0006, 32'hCAFE_0005, 32'hD00D_0004,
                                         32'hFEED_0003, 32'hBAAD_0002, 32'hABAD_0001};

  logic clk = 0, rst_n = 0, start = 0;
  logic cmd_valid, cmd_ready = 0, rsp_valid = 0, rsp_ready, done;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] rsp_data = '0;
  logic [EW-1:0] err_count;

  int n_chk = 0, n_err = 0, cyc = 0, mode = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] rq[$];
  logic [DW-1:0] eq[$];
  bit m_run = 0, m_done = 0;
  int m_iss = 0, m_err = 0;

  pattern_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OUTS(OUTS), .ADDRS(T_A), .DATAS(T_D)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .err_count(err_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] ta(int i); return T_A[i*AW +: AW]; endfunction
  function automatic logic [DW-1:0] td(int i); return T_D[i*DW +: DW]; endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one cycle minimum latency, patterns set by mode
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rq.delete();
      rsp_valid <= 0;
      cmd_ready <= 0;
    end else begin
      if (rsp_valid) void'(rq.pop_front());
      if (cmd_valid && cmd_ready) rq.push_back(mem[cmd_addr]);
      rsp_valid <= (rq.size() > 0) && (mode < 2 || cyc % 2 == 0);
      rsp_data  <= (rq.size() > 0) ? rq[0] : '0;
      cmd_ready <= (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 3 != 0);
    end
  end

  // reference model on the same pre-edge values
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_iss = 0; m_err = 0; eq.delete();
    end else begin
      bit fin;
      fin = m_run && m_iss == DEPTH && eq.size() == 0;
      if (start && !m_run) begin
        m_run = 1; m_done = 0; m_iss = 0; m_err = 0; eq.delete();
      end else begin
        if (rsp_valid && eq.size() > 0) begin
          if (rsp_data != eq.pop_front()) m_err++;
        end
        if (cmd_valid && cmd_ready) begin
          chk(cmd_addr == ta(m_iss), "R3 cmd_addr", cmd_addr, ta(m_iss));
          eq.push_back(td(m_iss));
          m_iss++;
        end
        if (fin) begin m_run = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit cv;
      cv = m_run && m_iss < DEPTH && eq.size() < OUTS;
      chk(cmd_valid == cv, "R4 cmd_valid", cmd_valid, cv);
      chk(err_count == m_err, "R5 err_count", err_count, m_err);
      chk(done == m_done, "R6 done", done, m_done);
      chk(rsp_ready == 1'b1, "R9 rsp_ready", rsp_ready, 1);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < DEPTH; i++) mem[ta(i)] = td(i);   // write pass in table order
    repeat (3) @(negedge clk);
    chk(done == 0 && err_count == 0 && cmd_valid == 0, "R1 in reset", {done, err_count, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && err_count == 0 && cmd_valid == 0, "R1 after reset", {done, err_count, cmd_valid}, 0);

    mode = 0; pulse_start(); wait_done();
    chk(err_count == 2, "R7 duplicates", err_count, 2);
    @(negedge clk); @(negedge clk);
    chk(done == 1, "R6 done held", done, 1);

    mem[8'h02] = 32'h1234_5678; mode = 1;
    pulse_start(); repeat (2) @(negedge clk);
    pulse_start();                            // R2: ignored while running
    wait_done();
    chk(err_count == 3, "R2 R5 corrupted word", err_count, 3);

    mem[8'h02] = td(2); mode = 2;
    pulse_start(); wait_done();
    chk(err_count == 2, "R4 R8 stalled pass", err_count, 2);

    mem[8'h00] = td(0); mem[8'h07] = td(1);
    mode = 0; pulse_start(); wait_done();
    chk(err_count == 2, "R7 early values now stored", err_count, 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule